// File: doc/BRIEF.md
# SDHCI Register Access Bridge

The bridge sits between a bus master that issues 8-bit, 16-bit and 32-bit accesses to a standard SD host controller register map and a controller register file that accepts whole 32-bit words only. Each front-side access is turned into at most one back-side word read followed by at most one back-side word write. Narrow reads return the addressed lanes of the word. Narrow writes are completed as read-modify-write of the containing word.

Four registers get special handling. The clock-control halfword is converted between the standard split divisor fields and the controller's native divisor. The native divisor is a single 10-bit ratio in bits 15..6, where 0 and 1 both mean divide-by-1. The transfer-mode halfword is held in a shadow register until the command halfword arrives, and the two are then written as one word, so the controller sees both halves at the same moment. Two configuration inputs let a word read of the capabilities register report no high-speed support and a word read of the present-state register report a card as inserted.

The front side is a valid/ready handshake with one access outstanding. A one-cycle done pulse marks completion. Read data is returned with the pulse, right-aligned and zero-extended.

Top module: `sdhci_access_bridge`

## Requirements
- R1: A byte read (size code 0) returns bits [8*a[1:0] +: 8] of the containing word, and a halfword read (size code 1) returns bits [16*a[1] +: 16], both zero-extended. Write data is right-aligned in the same way. This applies to every narrow read not covered by R4 or R8.
- R2: A byte or halfword write not covered by R5, R6 or R7 reads the containing word, replaces only the addressed lanes with the write data, and writes the word back.
- R3: A word access (size code 2) reads or writes the word unchanged, except for the bits named in R9 and R10.
- R4: A halfword read at offset 0x2C takes the native divisor N from bits 15..6, clears those bits, and places N/2 bits 7..0 in bits 15..8. When spec3_mode is high it also places N/2 bits 9..8 in bits 7..6. Bits 5..0 pass through.
- R5: A halfword write of value V at offset 0x2C forms the divisor D = V[15:8]. When spec3_mode is high, V[7:6] supply D bits 9..8. D is saturated at 1023. The new word keeps bits 31..16 of the old word, takes bits 5..0 from V, and puts D in bits 15..6.
- R6: A halfword write at offset 0x0C (transfer mode) updates only the low half of the shadow register. It makes no back-side read or write.
- R7: A halfword write of C at offset 0x0E (command) sets the high half of the shadow to C. It then makes exactly one back-side write, with no read, of {C, shadow low half} to the word at byte offset 0x0C.
- R8: Halfword reads at offsets 0x0C and 0x0E return the low and high halves of the shadow, with no back-side access. The shadow is zero after reset.
- R9: When hide_hispeed is high, a word read at offset 0x40 returns bit 21 cleared.
- R10: When force_present is high, a word read at offset 0x24 returns bit 16 set.
- R11: After reset, req_ready is high and rsp_done and both back-side strobes are low. An access is accepted on a clock edge with req_valid and req_ready high. rsp_done is high one cycle per access, and counting the accepting edge as 1 it is seen after:
  - edge 1 for R6 and R8 accesses;
  - edge 2 for word writes and command writes;
  - edge 3 for other reads;
  - edge 4 for read-modify-write accesses.
- R12: The masking of R9 and R10 applies to word reads only. Byte and halfword reads of offsets 0x24 and 0x40 return the stored bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spec3_mode | input | 1 | Use the two-bit upper divisor field in clock translation |
| hide_hispeed | input | 1 | Clear the high-speed bit on word reads of capabilities |
| force_present | input | 1 | Set the card-present bit on word reads of present state |
| req_valid | input | 1 | Front-side access request |
| req_ready | output | 1 | Bridge idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Byte address in the register map |
| req_wdata | input | 32 | Right-aligned write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Right-aligned read data, valid with rsp_done |
| bk_rd_en | output | 1 | Back-side word read strobe |
| bk_wr_en | output | 1 | Back-side word write strobe |
| bk_addr | output | ADDR_W-2 | Back-side word address |
| bk_wdata | output | 32 | Back-side write word |
| bk_rdata | input | 32 | Back-side read word, valid the cycle after bk_rd_en |

## Verification
The bench builds the bridge with its defaults: an 8-bit byte address, and a 10-bit native divisor starting at bit 6. The address width spans a 64-word map that reaches every special offset up to the capabilities word at 0x40, so a plain bench array can model the whole register file. The divisor defaults allow native values of 0, 1 and 1023 and the largest standard value with spec3_mode both low and high. They also cover the back-to-back shadow writes that build one command word.

// File: rtl/sdhci_bridge_pkg.sv
package sdhci_bridge_pkg;

    localparam int BUS_W = 32;
    localparam int LANES = BUS_W / 8;

    // Register offsets in the standard map (byte addresses).
    localparam int OFS_XFER_MODE = 'h0C;
    localparam int OFS_COMMAND   = 'h0E;
    localparam int OFS_PRESENT   = 'h24;
    localparam int OFS_CLK_CTL   = 'h2C;
    localparam int OFS_CAPS      = 'h40;

    localparam int PRESENT_CARD_BIT = 16;
    localparam int CAPS_HISPD_BIT   = 21;

    // Standard divisor fields inside the clock-control halfword.
    localparam int STD_LO_LSB = 8;
    localparam int STD_LO_W   = 8;
    localparam int STD_HI_LSB = 6;
    localparam int STD_HI_W   = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_CAP  = 2'd2,
        ST_WR   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/sdhci_lane_merge.sv
module sdhci_lane_merge
    import sdhci_bridge_pkg::*;
(
    input  logic [BUS_W-1:0] old_word,
    input  logic [BUS_W-1:0] new_data,
    input  acc_size_e        size,
    input  logic [1:0]       lane_ofs,
    output logic [BUS_W-1:0] merged,
    output logic [BUS_W-1:0] extracted
);

    logic [BUS_W-1:0] shifted_new;
    logic [BUS_W-1:0] shifted_old;
    logic [LANES-1:0] lane_en;

    always_comb begin
        shifted_new = new_data << {lane_ofs, 3'b000};
        shifted_old = old_word >> {lane_ofs, 3'b000};
        unique case (size)
            SZ_BYTE: begin
                lane_en   = LANES'(1) << lane_ofs;
                extracted = {{(BUS_W-8){1'b0}}, shifted_old[7:0]};
            end
            SZ_HALF: begin
                lane_en   = LANES'(3) << lane_ofs;
                extracted = {{(BUS_W-16){1'b0}}, shifted_old[15:0]};
            end
            default: begin
                lane_en   = {LANES{1'b1}};
                extracted = shifted_old;
            end
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[8*g +: 8] = lane_en[g] ? shifted_new[8*g +: 8] : old_word[8*g +: 8];
    end

endmodule

// File: rtl/sdhci_clkdiv_xlate.sv
module sdhci_clkdiv_xlate
    import sdhci_bridge_pkg::*;
#(
    parameter int DIV_W   = 10,
    parameter int DIV_LSB = 6
) (
    input  logic             spec3,
    input  logic [BUS_W-1:0] raw_word,
    input  logic [15:0]      host_half,
    output logic [15:0]      std_half,
    output logic [BUS_W-1:0] native_word
);

    localparam int REQ_W = STD_LO_W + STD_HI_W + 1;
    localparam int LIMIT = (1 << DIV_W) - 1;
    localparam logic [REQ_W-1:0] LIMIT_V  = REQ_W'(LIMIT);
    localparam logic [15:0]      NAT_MASK = 16'(LIMIT << DIV_LSB);

    logic [DIV_W-1:0] nat_div;
    logic [DIV_W-1:0] halved;
    logic [REQ_W-1:0] req_div;
    logic [DIV_W-1:0] sat_div;
    logic [15:0]      low_half;

    // Native to standard (read direction).
    always_comb begin
        nat_div  = raw_word[DIV_LSB +: DIV_W];
        halved   = nat_div >> 1;
        std_half = raw_word[15:0] & ~NAT_MASK;
        std_half[STD_LO_LSB +: STD_LO_W] = halved[STD_LO_W-1:0];
        if (spec3) begin
            std_half[STD_HI_LSB +: STD_HI_W] = halved[STD_LO_W +: STD_HI_W];
        end
    end

    // Standard to native (write direction), upper halfword kept.
    always_comb begin
        req_div = {1'b0,
                   (spec3 ? host_half[STD_HI_LSB +: STD_HI_W] : {STD_HI_W{1'b0}}),
                   host_half[STD_LO_LSB +: STD_LO_W]};
        sat_div = (req_div > LIMIT_V) ? DIV_W'(LIMIT) : req_div[DIV_W-1:0];
        low_half = (host_half & ~NAT_MASK) | (16'(sat_div) << DIV_LSB);
        native_word = {raw_word[BUS_W-1:16], low_half};
    end

endmodule

// File: rtl/sdhci_status_filter.sv
module sdhci_status_filter
    import sdhci_bridge_pkg::*;
(
    input  logic [BUS_W-1:0] word_in,
    input  logic             is_caps,
    input  logic             is_present,
    input  logic             hide_hispeed,
    input  logic             force_present,
    output logic [BUS_W-1:0] word_out
);

    always_comb begin
        word_out = word_in;
        if (is_caps && hide_hispeed) begin
            word_out[CAPS_HISPD_BIT] = 1'b0;
        end
        if (is_present && force_present) begin
            word_out[PRESENT_CARD_BIT] = 1'b1;
        end
    end

endmodule

// File: rtl/sdhci_access_bridge.sv
module sdhci_access_bridge
    import sdhci_bridge_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DIV_W   = 10,
    parameter int DIV_LSB = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spec3_mode,
    input  logic              hide_hispeed,
    input  logic              force_present,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_done,
    output logic [31:0]       rsp_rdata,
    output logic              bk_rd_en,
    output logic              bk_wr_en,
    output logic [ADDR_W-3:0] bk_addr,
    output logic [31:0]       bk_wdata,
    input  logic [31:0]       bk_rdata
);

    localparam int WORD_AW = ADDR_W - 2;

    localparam logic [ADDR_W-1:0]  A_TM   = ADDR_W'(OFS_XFER_MODE);
    localparam logic [ADDR_W-1:0]  A_CMD  = ADDR_W'(OFS_COMMAND);
    localparam logic [ADDR_W-1:0]  A_PRES = ADDR_W'(OFS_PRESENT);
    localparam logic [ADDR_W-1:0]  A_CLK  = ADDR_W'(OFS_CLK_CTL);
    localparam logic [ADDR_W-1:0]  A_CAPS = ADDR_W'(OFS_CAPS);
    localparam logic [WORD_AW-1:0] W_TM   = WORD_AW'(OFS_XFER_MODE / 4);

    typedef struct packed {
        seq_state_e         st;
        logic               wr;
        acc_size_e          sz;
        logic [ADDR_W-1:0]  addr;
        logic [BUS_W-1:0]   wdata;
        logic [BUS_W-1:0]   shadow;
        logic [WORD_AW-1:0] baddr;
        logic [BUS_W-1:0]   bwdata;
        logic [BUS_W-1:0]   rdata;
        logic               done;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic       accept;
    acc_size_e  in_size;
    logic       in_hit_tm;
    logic       in_hit_cmd;
    logic [1:0] lane_ofs;

    logic [BUS_W-1:0] lm_merged;
    logic [BUS_W-1:0] lm_extracted;
    logic [15:0]      xl_half;
    logic [BUS_W-1:0] xl_word;
    logic [BUS_W-1:0] filt_word;

    // Front-side decode.
    always_comb begin
        in_size    = acc_size_e'(req_size);
        accept     = req_valid && req_ready;
        in_hit_tm  = (in_size == SZ_HALF) && (req_addr == A_TM);
        in_hit_cmd = (in_size == SZ_HALF) && (req_addr == A_CMD);
        lane_ofs   = (r_q.sz == SZ_HALF) ? {r_q.addr[1], 1'b0} : r_q.addr[1:0];
    end

    sdhci_lane_merge u_lanes (
        .old_word  (bk_rdata),
        .new_data  (r_q.wdata),
        .size      (r_q.sz),
        .lane_ofs  (lane_ofs),
        .merged    (lm_merged),
        .extracted (lm_extracted)
    );

    sdhci_clkdiv_xlate #(
        .DIV_W   (DIV_W),
        .DIV_LSB (DIV_LSB)
    ) u_clkdiv (
        .spec3       (spec3_mode),
        .raw_word    (bk_rdata),
        .host_half   (r_q.wdata[15:0]),
        .std_half    (xl_half),
        .native_word (xl_word)
    );

    sdhci_status_filter u_filter (
        .word_in       (bk_rdata),
        .is_caps       (r_q.addr == A_CAPS),
        .is_present    (r_q.addr == A_PRES),
        .hide_hispeed  (hide_hispeed),
        .force_present (force_present),
        .word_out      (filt_word)
    );

    // Next-state computation.
    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.wr    = req_write;
                    r_d.sz    = in_size;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.baddr = req_addr[ADDR_W-1:2];
                    if (req_write) begin
                        if (in_hit_tm) begin
                            r_d.shadow[15:0] = req_wdata[15:0];
                            r_d.done         = 1'b1;
                        end else if (in_hit_cmd) begin
                            r_d.shadow[31:16] = req_wdata[15:0];
                            r_d.bwdata        = {req_wdata[15:0], r_q.shadow[15:0]};
                            r_d.baddr         = W_TM;
                            r_d.st            = ST_WR;
                        end else if (in_size == SZ_WORD) begin
                            r_d.bwdata = req_wdata;
                            r_d.st     = ST_WR;
                        end else begin
                            r_d.st = ST_RD;
                        end
                    end else begin
                        if (in_hit_tm) begin
                            r_d.rdata = {16'h0000, r_q.shadow[15:0]};
                            r_d.done  = 1'b1;
                        end else if (in_hit_cmd) begin
                            r_d.rdata = {16'h0000, r_q.shadow[31:16]};
                            r_d.done  = 1'b1;
                        end else begin
                            r_d.st = ST_RD;
                        end
                    end
                end
            end
            ST_RD: begin
                r_d.st = ST_CAP;
            end
            ST_CAP: begin
                if (r_q.wr) begin
                    if ((r_q.sz == SZ_HALF) && (r_q.addr == A_CLK)) begin
                        r_d.bwdata = xl_word;
                    end else begin
                        r_d.bwdata = lm_merged;
                    end
                    r_d.st = ST_WR;
                end else begin
                    if (r_q.sz == SZ_WORD) begin
                        r_d.rdata = filt_word;
                    end else if ((r_q.sz == SZ_HALF) && (r_q.addr == A_CLK)) begin
                        r_d.rdata = {16'h0000, xl_half};
                    end else begin
                        r_d.rdata = lm_extracted;
                    end
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            ST_WR: begin
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign bk_rd_en  = (r_q.st == ST_RD);
    assign bk_wr_en  = (r_q.st == ST_WR);
    assign bk_addr   = r_q.baddr;
    assign bk_wdata  = r_q.bwdata;
    assign rsp_done  = r_q.done;
    assign rsp_rdata = r_q.rdata;

    // Back-side strobes never overlap and a read strobe lasts one cycle.
    p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bk_rd_en && bk_wr_en));
    p_rd_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bk_rd_en |=> !bk_rd_en);

    // Transfer-mode halfword write stays inside the bridge.
    p_tm_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write && in_hit_tm) |=> (!bk_wr_en && !bk_rd_en && rsp_done));

    // Command halfword write goes straight to a single word write.
    p_cmd_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_write && in_hit_cmd) |=> (bk_wr_en && (bk_addr == W_TM)));

    // Status masking on word reads.
    p_caps_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !r_q.wr && (r_q.sz == SZ_WORD) && (r_q.addr == A_CAPS) && hide_hispeed)
            |-> !rsp_rdata[CAPS_HISPD_BIT]);
    p_present_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !r_q.wr && (r_q.sz == SZ_WORD) && (r_q.addr == A_PRES) && force_present)
            |-> rsp_rdata[PRESENT_CARD_BIT]);

endmodule

// File: tb/sdhci_access_bridge_test.sv
`timescale 1ns/1ps
module sdhci_access_bridge_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spec3_mode = 1'b0;
    logic        hide_hispeed = 1'b0;
    logic        force_present = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [7:0]  req_addr = 8'h00;
    logic [31:0] req_wdata = 32'h0;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic        bk_rd_en;
    logic        bk_wr_en;
    logic [5:0]  bk_addr;
    logic [31:0] bk_wdata;
    logic [31:0] bk_rdata = 32'h0;

    logic [31:0] mem     [64];
    logic [31:0] ref_mem [64];
    logic [31:0] ref_shadow = 32'h0;

    int n_chk = 0;
    int n_fail = 0;
    int n_wr = 0;
    logic busy = 1'b0;

    always #2.5 clk = ~clk;

    sdhci_access_bridge uut (
        .clk(clk), .rst_n(rst_n),
        .spec3_mode(spec3_mode), .hide_hispeed(hide_hispeed), .force_present(force_present),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bk_rd_en(bk_rd_en), .bk_wr_en(bk_wr_en), .bk_addr(bk_addr),
        .bk_wdata(bk_wdata), .bk_rdata(bk_rdata)
    );

    function automatic logic [31:0] seed_word(int i);
        return (32'(i) * 32'h01010101) ^ 32'hA5C30000;
    endfunction

    // Register file model: one-cycle registered read.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= seed_word(i);
        end else begin
            if (bk_wr_en) mem[bk_addr] <= bk_wdata;
            if (bk_rd_en) bk_rdata <= mem[bk_addr];
        end
    end

    always @(posedge clk) if (rst_n && bk_wr_en) n_wr++;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", what, act, exp);
        end
    endtask

    // Per-clock check: no completion pulse outside an access (R11).
    always @(negedge clk) begin
        if (rst_n && !busy && rsp_done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R11 stray done: got 1 expected 0");
        end
    end

    function automatic logic [31:0] model_read(logic [1:0] sz, logic [7:0] a);
        logic [31:0] w, r, dv;
        w = ref_mem[a[7:2]];
        if (sz == 2'd1 && a == 8'h0C) return {16'h0, ref_shadow[15:0]};
        if (sz == 2'd1 && a == 8'h0E) return {16'h0, ref_shadow[31:16]};
        if (sz == 2'd1 && a == 8'h2C) begin
            dv = ((w >> 6) & 32'h3FF) / 2;
            r  = (w & 32'hFFFF) & ~(32'h3FF << 6);
            r  = r | ((dv & 32'hFF) << 8);
            if (spec3_mode) r = r | (((dv >> 8) & 32'h3) << 6);
            return r;
        end
        if (sz == 2'd2) begin
            r = w;
            if (a == 8'h40 && hide_hispeed) r[21] = 1'b0;
            if (a == 8'h24 && force_present) r[16] = 1'b1;
            return r;
        end
        if (sz == 2'd0) return (w >> (8 * a[1:0])) & 32'hFF;
        return (w >> (16 * a[1])) & 32'hFFFF;
    endfunction

    task automatic model_write(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] v);
        logic [31:0] w, dv, m;
        w = ref_mem[a[7:2]];
        if (sz == 2'd1 && a == 8'h0C) begin
            ref_shadow[15:0] = v[15:0];
        end else if (sz == 2'd1 && a == 8'h0E) begin
            ref_shadow[31:16] = v[15:0];
            ref_mem[3] = ref_shadow;
        end else if (sz == 2'd1 && a == 8'h2C) begin
            dv = (v >> 8) & 32'hFF;
            if (spec3_mode) dv = dv | (((v >> 6) & 32'h3) << 8);
            if (dv > 1023) dv = 1023;
            ref_mem[a[7:2]] = (w & 32'hFFFF0000) | (v & 32'h3F) | (dv << 6);
        end else if (sz == 2'd2) begin
            ref_mem[a[7:2]] = v;
        end else begin
            m = (sz == 2'd0) ? (32'hFF << (8 * a[1:0])) : (32'hFFFF << (16 * a[1]));
            ref_mem[a[7:2]] = (w & ~m) | ((v << (8 * a[1:0])) & m);
        end
    endtask

    task automatic access(input logic wr, input logic [1:0] sz, input logic [7:0] a,
                          input logic [31:0] v, input string tag);
        int lat, n, wr_before, exp_wr, widx;
        logic [31:0] exp_rd;
        logic shadow_op;
        shadow_op = (sz == 2'd1) && (a == 8'h0C || (a == 8'h0E && !wr));
        if (shadow_op) lat = 1;
        else if (wr && (sz == 2'd2 || (sz == 2'd1 && a == 8'h0E))) lat = 2;
        else if (!wr) lat = 3;
        else lat = 4;
        exp_wr = (wr && !(sz == 2'd1 && a == 8'h0C)) ? 1 : 0;
        widx   = (wr && sz == 2'd1 && a == 8'h0E) ? 3 : int'(a[7:2]);
        exp_rd = model_read(sz, a);
        if (wr) model_write(sz, a, v);
        wr_before = n_wr;
        @(negedge clk);
        busy = 1'b1;
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = v;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            req_valid = 1'b0;
        end while (!rsp_done && n < 12);
        chk($sformatf("%s R11 latency", tag), 32'(n), 32'(lat));
        if (!wr) chk($sformatf("%s read data @%h", tag, a), rsp_rdata, exp_rd);
        chk($sformatf("%s back-side writes", tag), 32'(n_wr - wr_before), 32'(exp_wr));
        if (wr) chk($sformatf("%s stored word %0d", tag, widx), mem[widx], ref_mem[widx]);
        @(posedge clk);
        #1 busy = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(5.0 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) ref_mem[i] = seed_word(i);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 reset ready", 32'(req_ready), 32'd1);
        chk("R11 reset done", 32'(rsp_done), 32'd0);
        chk("R11 reset strobes", {30'd0, bk_rd_en, bk_wr_en}, 32'd0);

        access(0, 2'd1, 8'h0C, 0, "R8 shadow after reset");
        access(0, 2'd2, 8'h50, 0, "R3 word read");
        for (int b = 0; b < 4; b++) access(0, 2'd0, 8'h50 + 8'(b), 0, "R1 byte read");
        access(0, 2'd1, 8'h50, 0, "R1 low half read");
        access(0, 2'd1, 8'h52, 0, "R1 high half read");
        access(1, 2'd0, 8'h51, 32'h000000EE, "R2 byte write");
        access(1, 2'd1, 8'h52, 32'h0000BEEF, "R2 half write");
        access(1, 2'd0, 8'h50, 32'h12345677, "R2 byte write upper ignored");
        access(0, 2'd2, 8'h50, 0, "R3 word read after merge");
        access(1, 2'd2, 8'h54, 32'hCAFEF00D, "R3 word write");
        access(0, 2'd2, 8'h54, 0, "R3 word readback");

        // Clock divisor read translation
        access(1, 2'd2, 8'h2C, 32'h12340000 | (32'd677 << 6) | 32'h7, "R3 clock word set");
        access(0, 2'd1, 8'h2C, 0, "R4 clock read legacy");
        spec3_mode = 1'b1;
        access(0, 2'd1, 8'h2C, 0, "R4 clock read spec3");
        access(1, 2'd2, 8'h2C, 32'h0000FFC0, "R3 clock native 1023");
        access(0, 2'd1, 8'h2C, 0, "R4 native 1023 spec3");
        access(1, 2'd2, 8'h2C, 32'h00000040, "R3 clock native 1");
        access(0, 2'd1, 8'h2C, 0, "R4 native 1");
        access(1, 2'd2, 8'h2C, 32'h0000003F, "R3 clock native 0");
        access(0, 2'd1, 8'h2C, 0, "R4 native 0");
        access(0, 2'd0, 8'h2D, 0, "R1 clock byte raw");

        // Clock divisor write translation
        access(1, 2'd2, 8'h2C, 32'h9876ABCD, "R3 clock preset");
        access(1, 2'd1, 8'h2C, 32'h0000A5C7, "R5 clock write spec3");
        access(0, 2'd2, 8'h2C, 0, "R5 clock word after spec3 write");
        spec3_mode = 1'b0;
        access(1, 2'd1, 8'h2C, 32'h00005AFF, "R5 clock write legacy");
        access(0, 2'd2, 8'h2C, 0, "R5 clock word after legacy write");
        access(0, 2'd1, 8'h2C, 0, "R4 clock read after write");

        // Transfer-mode / command pairing
        access(1, 2'd1, 8'h0C, 32'h00001357, "R6 transfer half write");
        access(0, 2'd2, 8'h0C, 0, "R6 word unchanged");
        access(0, 2'd1, 8'h0C, 0, "R8 transfer shadow read");
        access(1, 2'd1, 8'h0E, 32'h00002468, "R7 command write");
        access(0, 2'd2, 8'h0C, 0, "R7 combined word");
        access(0, 2'd1, 8'h0E, 0, "R8 command shadow read");
        access(1, 2'd1, 8'h0C, 32'h00000001, "R6 transfer rewrite");
        access(1, 2'd1, 8'h0E, 32'h000000FF, "R7 second command");
        access(0, 2'd2, 8'h0C, 0, "R7 second combined word");

        // Capabilities masking
        access(1, 2'd2, 8'h40, 32'hFFFFFFFF, "R3 caps set");
        access(0, 2'd2, 8'h40, 0, "R9 caps unmasked");
        hide_hispeed = 1'b1;
        access(0, 2'd2, 8'h40, 0, "R9 caps masked");
        access(0, 2'd0, 8'h42, 0, "R12 caps byte raw");
        access(0, 2'd1, 8'h42, 0, "R12 caps half raw");
        hide_hispeed = 1'b0;

        // Present-state forcing
        access(1, 2'd2, 8'h24, 32'h00000000, "R3 present clear");
        force_present = 1'b1;
        access(0, 2'd2, 8'h24, 0, "R10 present forced");
        access(0, 2'd0, 8'h26, 0, "R12 present byte raw");
        force_present = 1'b0;
        access(0, 2'd2, 8'h24, 0, "R10 present not forced");

        repeat (3) @(posedge clk);
        report();
        $finish;
    end

endmodule